// File: doc/BRIEF.md
# Asynchronous Memory Bank Controller

This block connects a 32-bit word request port to four banks of asynchronous external devices such as SRAM, ROM, flash or memory-mapped I/O. Each bank has its own active-low select line and shares one read strobe, one write strobe, an address bus and a data bus. A request arrives with a word address. The controller finds the bank from a fixed address window and then runs the external bus cycles that the bank needs, using that bank's own timing and bus width.

A bank can be 8, 16 or 32 bits wide. On a narrow bank, one 32-bit word becomes a burst of narrow accesses. The lowest part goes first and the external address steps by one for each part. Read parts are collected into one word, which is returned with a single-cycle response pulse. Write words are split into lanes on the low bits of the data bus.

The windows are not contiguous. Bank 0 is shorter than its slot, and the gap after it is not folded into bank 1. A request that lands in the gap, or above all four windows, is answered at once with an error flag and causes no external activity.

The sequencer has six states:
- IDLE: ready for a request.
- SETUP: select asserted, address and data driven, strobe high.
- STROBE: read or write strobe low.
- HOLD: strobe high again, select still asserted.
- DONE: one-cycle response.
- FAULT: one-cycle error response.

The transitions are:
- IDLE→SETUP on an accepted request that hits a window.
- IDLE→FAULT on an accepted request that misses.
- SETUP→STROBE and STROBE→HOLD when the interval count expires.
- HOLD→SETUP when the count expires and parts remain.
- HOLD→DONE when the count expires after the last part.
- DONE→IDLE and FAULT→IDLE unconditionally.

Top module: `async_bank_ctrl`

## Requirements
- R1: During and straight after reset, `req_ready` is 1, all four `ext_cs_n` bits are 1, `ext_rd_n` and `ext_wr_n` are 1, and `rsp_valid` is 0.
- R2: Bank decode works as follows:
  - Address bits [25:24] select the bank, and bits [26] must be 0.
  - Bank 0 accepts offsets 0 to 0xDFFFFF. Banks 1 to 3 accept their whole 2^24-word offset range.
  - A hit drives `ext_cs_n[bank]` low and the other three select bits high.
- R3: These addresses miss: bank 0 offsets 0xE00000 to 0xFFFFFF, and any address with bit 26 set. No remapping takes place. A missed request raises `rsp_valid` and `rsp_err` together in the cycle after acceptance, and no select or strobe goes low.
- R4: Each external part has three phases, each lasting the count in the bank's 4-bit field:
  - setup lasts `cfg_setup[4b+:4]` cycles;
  - strobe-low lasts `cfg_strobe[4b+:4]` cycles;
  - hold lasts `cfg_hold[4b+:4]` cycles.
  
  A field value of 0 counts as 1. `rsp_valid` rises N·(S+T+H)+1 cycles after the accepting edge.
- R5: The width field `cfg_width[2b+:2]` sets the part count N:
  - 0 selects 8 bits (N = 4);
  - 1 selects 16 bits (N = 2);
  - 2 and 3 select 32 bits (N = 1).
  
  Exactly N separate strobe pulses occur per request.
- R6: Parts go out least-significant first. During part k, `ext_addr` is:
  - offset·4+k on an 8-bit bank;
  - offset·2+k on a 16-bit bank;
  - the offset itself on a 32-bit bank.
  
  `ext_addr` stays stable while a strobe is low.
- R7: On a write, during part k, `ext_dout` carries the matching data slice zero-extended on the low bits:
  - byte k of the write data on an 8-bit bank;
  - half-word k on a 16-bit bank;
  - the whole word on a 32-bit bank.
  
  `ext_oe` is 1 whenever `ext_wr_n` is 0 and 0 whenever `ext_rd_n` is 0.
- R8: On a read, `ext_din` is sampled on the last cycle of each strobe-low phase. The low 8 or 16 bits of part k become byte or half-word k of `rsp_rdata` (the full 32 bits on a 32-bit bank). `rsp_rdata` is valid while `rsp_valid` is 1.
- R9: The select line stays low without change from the first setup cycle to the last hold cycle of a request. A strobe is low only while exactly one select is low.
- R10: `req_ready` is 0 from the cycle after acceptance until the response cycle has passed. `rsp_valid` lasts exactly one cycle, and `rsp_err` is 0 on a request that hits a window.
- R11: At most one select is low at a time, and the read and write strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (27) | Word address |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request missed every window |
| rsp_rdata | output | 32 | Packed read word |
| cfg_setup | input | 16 | Setup count, 4 bits per bank |
| cfg_strobe | input | 16 | Strobe-low count, 4 bits per bank |
| cfg_hold | input | 16 | Hold count, 4 bits per bank |
| cfg_width | input | 8 | Bus width code, 2 bits per bank |
| ext_cs_n | output | 4 | Bank selects, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_addr | output | WIN_LOG2+2 (26) | External part address |
| ext_dout | output | 32 | External write data |
| ext_oe | output | 1 | Write data drive enable |
| ext_din | input | 32 | External read data |

## Verification
The assertions check the following on every cycle:
- only one select is low at a time;
- the two strobes are never low together;
- a strobe is low only under a single select;
- the select does not change during a request;
- the address does not move during a strobe;
- the data drive direction matches the strobe;
- the controller drops ready after it accepts a request;
- the response is a single-cycle pulse;
- an error response comes with no select low.

Some behaviour depends on the bank configuration, and only the bench scenarios can show it. These are the exact phase lengths and total latency, the number of parts, the lane order, the external addresses, and the packed and unpacked data. The bench shows them by sweeping every bank through every width code and several timing sets, including the zero and maximum counts, and by probing the edges of each window.

// File: rtl/abc_pkg.sv
package abc_pkg;

    localparam int NBANK   = 4;
    localparam int DATA_W  = 32;

    localparam logic [1:0] BW_8  = 2'd0;
    localparam logic [1:0] BW_16 = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE,
        ST_FAULT
    } state_e;

    // index of the final narrow part for a width code
    function automatic logic [1:0] last_index(input logic [1:0] bw);
        case (bw)
            BW_8:    return 2'd3;
            BW_16:   return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/abc_decode.sv
module abc_decode #(
    parameter int ADDR_W      = 27,
    parameter int WIN_LOG2    = 24,
    parameter int BANK0_WORDS = 14680064
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit,
    output logic [1:0]          bank,
    output logic [WIN_LOG2-1:0] offset
);
    localparam logic [WIN_LOG2:0] B0_LIMIT = BANK0_WORDS[WIN_LOG2:0];

    logic upper_ok;

    assign bank   = addr[WIN_LOG2 +: 2];
    assign offset = addr[WIN_LOG2-1:0];

    generate
        if (ADDR_W > WIN_LOG2 + 2) begin : g_upper
            assign upper_ok = (addr[ADDR_W-1:WIN_LOG2+2] == '0);
        end else begin : g_no_upper
            assign upper_ok = 1'b1;
        end
    endgenerate

    // bank 0 is shorter than its slot; the gap is never folded forward
    assign hit = upper_ok && ((bank != 2'd0) || ({1'b0, offset} < B0_LIMIT));

endmodule

// File: rtl/abc_timer.sv
module abc_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (val == '0) ? '0 : val - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/abc_lanes.sv
module abc_lanes
    import abc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic [1:0]        bw,
    input  logic [1:0]        part,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rword,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (capture) begin
            case (bw)
                BW_8:    acc_q[{part, 3'b000} +: 8]     <= din[7:0];
                BW_16:   acc_q[{part[0], 4'b0000} +: 16] <= din[15:0];
                default: acc_q                          <= din;
            endcase
        end
    end

    always_comb begin
        case (bw)
            BW_8:    dout = {24'd0, wdata[{part, 3'b000} +: 8]};
            BW_16:   dout = {16'd0, wdata[{part[0], 4'b0000} +: 16]};
            default: dout = wdata;
        endcase
    end

    assign rword = acc_q;

endmodule

// File: rtl/async_bank_ctrl.sv
module async_bank_ctrl
    import abc_pkg::*;
#(
    parameter int ADDR_W      = 27,
    parameter int WIN_LOG2    = 24,
    parameter int BANK0_WORDS = 14680064,
    parameter int TIM_W       = 4,
    localparam int EXT_AW     = WIN_LOG2 + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rsp_valid,
    output logic                   rsp_err,
    output logic [DATA_W-1:0]      rsp_rdata,
    input  logic [NBANK*TIM_W-1:0] cfg_setup,
    input  logic [NBANK*TIM_W-1:0] cfg_strobe,
    input  logic [NBANK*TIM_W-1:0] cfg_hold,
    input  logic [NBANK*2-1:0]     cfg_width,
    output logic [NBANK-1:0]       ext_cs_n,
    output logic                   ext_rd_n,
    output logic                   ext_wr_n,
    output logic [EXT_AW-1:0]      ext_addr,
    output logic [DATA_W-1:0]      ext_dout,
    output logic                   ext_oe,
    input  logic [DATA_W-1:0]      ext_din
);
    state_e state_q, state_d;

    logic                dec_hit;
    logic [1:0]          dec_bank;
    logic [WIN_LOG2-1:0] dec_off;

    logic [1:0]          bank_q, bw_q, part_q, sel_bank;
    logic                wr_q;
    logic [WIN_LOG2-1:0] off_q;
    logic [DATA_W-1:0]   wdata_q;

    logic                accept, on_last, busy;
    logic                tmr_load, tmr_done;
    logic [TIM_W-1:0]    tmr_val;

    abc_decode #(
        .ADDR_W     (ADDR_W),
        .WIN_LOG2   (WIN_LOG2),
        .BANK0_WORDS(BANK0_WORDS)
    ) u_decode (
        .addr  (req_addr),
        .hit   (dec_hit),
        .bank  (dec_bank),
        .offset(dec_off)
    );

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign sel_bank = accept ? dec_bank : bank_q;
    assign on_last  = (part_q == last_index(bw_q));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = dec_hit ? ST_SETUP : ST_FAULT;
            ST_SETUP:  if (tmr_done)  state_d = ST_STROBE;
            ST_STROBE: if (tmr_done)  state_d = ST_HOLD;
            ST_HOLD:   if (tmr_done)  state_d = on_last ? ST_DONE : ST_SETUP;
            ST_DONE:                  state_d = ST_IDLE;
            ST_FAULT:                 state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // interval count for the phase being entered
    assign tmr_load = (state_d != state_q);
    always_comb begin
        case (state_d)
            ST_SETUP:  tmr_val = cfg_setup[sel_bank*TIM_W +: TIM_W];
            ST_STROBE: tmr_val = cfg_strobe[sel_bank*TIM_W +: TIM_W];
            ST_HOLD:   tmr_val = cfg_hold[sel_bank*TIM_W +: TIM_W];
            default:   tmr_val = '0;
        endcase
    end

    abc_timer #(.W(TIM_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .val  (tmr_val),
        .done (tmr_done)
    );

    // request capture and part index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q  <= '0;
            bw_q    <= '0;
            part_q  <= '0;
            wr_q    <= 1'b0;
            off_q   <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            bank_q  <= dec_bank;
            bw_q    <= cfg_width[dec_bank*2 +: 2];
            part_q  <= '0;
            wr_q    <= req_write;
            off_q   <= dec_off;
            wdata_q <= req_wdata;
        end else if (state_q == ST_HOLD && tmr_done && !on_last) begin
            part_q  <= part_q + 2'd1;
        end
    end

    abc_lanes u_lanes (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .capture(state_q == ST_STROBE && tmr_done && !wr_q),
        .bw     (bw_q),
        .part   (part_q),
        .din    (ext_din),
        .wdata  (wdata_q),
        .rword  (rsp_rdata),
        .dout   (ext_dout)
    );

    // outputs
    assign busy = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_DONE) || (state_q == ST_FAULT);
        rsp_err   = (state_q == ST_FAULT);
        ext_cs_n  = '1;
        if (busy) ext_cs_n[bank_q] = 1'b0;
        ext_rd_n  = !((state_q == ST_STROBE) && !wr_q);
        ext_wr_n  = !((state_q == ST_STROBE) && wr_q);
        ext_oe    = busy && wr_q;
        case (bw_q)
            BW_8:    ext_addr = {off_q, part_q};
            BW_16:   ext_addr = {1'b0, off_q, part_q[0]};
            default: ext_addr = {2'b00, off_q};
        endcase
    end

endmodule

// File: rtl/abc_checker.sv
module abc_checker #(
    parameter int EXT_AW = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [3:0]        ext_cs_n,
    input logic              ext_rd_n,
    input logic              ext_wr_n,
    input logic [EXT_AW-1:0] ext_addr,
    input logic              ext_oe
);
    logic strobe_low, sel_any;
    assign strobe_low = !ext_rd_n || !ext_wr_n;
    assign sel_any    = |(~ext_cs_n);

    assert_one_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n));

    assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));

    assert_strobe_under_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_low |-> ($countones(~ext_cs_n) == 1));

    assert_select_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_any && $past(sel_any)) |-> $stable(ext_cs_n));

    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_low && $past(strobe_low)) |-> $stable(ext_addr));

    assert_write_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_wr_n |-> ext_oe) and (!ext_rd_n |-> !ext_oe));

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_err_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && !sel_any && !strobe_low));

endmodule

bind async_bank_ctrl abc_checker #(.EXT_AW(EXT_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .ext_cs_n (ext_cs_n),
    .ext_rd_n (ext_rd_n),
    .ext_wr_n (ext_wr_n),
    .ext_addr (ext_addr),
    .ext_oe   (ext_oe)
);

// File: tb/sim_async_bank_ctrl.sv
module sim_async_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write;
    logic [26:0] req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [15:0] cfg_setup, cfg_strobe, cfg_hold;
    logic [7:0]  cfg_width;
    logic [3:0]  ext_cs_n;
    logic        ext_rd_n, ext_wr_n, ext_oe;
    logic [25:0] ext_addr;
    logic [31:0] ext_dout, ext_din;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    int tS[5] = '{0, 1, 2, 3, 15};
    int tT[5] = '{0, 1, 3, 1, 15};
    int tH[5] = '{0, 1, 1, 2, 15};

    always #10 clk = ~clk;

    async_bank_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
        .cfg_width(cfg_width),
        .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
        .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_oe(ext_oe),
        .ext_din(ext_din)
    );

    function automatic logic [31:0] memf(input logic [25:0] a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    assign ext_din = memf(ext_addr);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(1'b0, "WDOG", "global watchdog", 64'(cycles), 64'd150000);
            summary();
        end
    end

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic set_bank(input int b, input int w, input int s, input int t, input int h);
        cfg_width[b*2 +: 2]  = 2'(w);
        cfg_setup[b*4 +: 4]  = 4'(s);
        cfg_strobe[b*4 +: 4] = 4'(t);
        cfg_hold[b*4 +: 4]   = 4'(h);
    endtask

    task automatic do_txn(input int b, input bit wr, input logic [23:0] off, input logic [31:0] wd);
        int w      = int'(cfg_width[b*2 +: 2]);
        int np     = (w == 0) ? 4 : (w == 1) ? 2 : 1;
        int s      = eff(int'(cfg_setup[b*4 +: 4]));
        int t      = eff(int'(cfg_strobe[b*4 +: 4]));
        int h      = eff(int'(cfg_hold[b*4 +: 4]));
        int lat    = 1;
        int strb   = 0;
        int pulses = 0;
        int cs_bad = 0, rdy_bad = 0, adr_bad = 0, dat_bad = 0, wrong_strb = 0;
        bit prev   = 1'b0;
        bit sel_ok;
        logic [3:0]  exp_cs = ~(4'b0001 << b);
        logic [31:0] exp_rd = '0;
        logic [25:0] ea;
        logic [31:0] ed;
        for (int k = 0; k < np; k++) begin
            ea = (w == 0) ? {off, 2'(k)} : (w == 1) ? {1'b0, off, 1'(k)} : {2'b00, off};
            if (w == 0)      exp_rd[8*k +: 8]   = memf(ea)[7:0];
            else if (w == 1) exp_rd[16*k +: 16] = memf(ea)[15:0];
            else             exp_rd             = memf(ea);
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr;
        req_addr  = {1'b0, 2'(b), off}; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        sel_ok = (ext_cs_n == exp_cs);
        while (!rsp_valid && lat < 400) begin
            bit st = wr ? !ext_wr_n : !ext_rd_n;
            if ((wr ? !ext_rd_n : !ext_wr_n)) wrong_strb++;
            if (ext_cs_n != exp_cs) cs_bad++;
            if (req_ready) rdy_bad++;
            if (st) strb++;
            if (st && !prev) begin
                ea = (w == 0) ? {off, 2'(pulses)} : (w == 1) ? {1'b0, off, 1'(pulses)} : {2'b00, off};
                ed = (w == 0) ? {24'd0, wd[8*pulses +: 8]} : (w == 1) ? {16'd0, wd[16*pulses +: 16]} : wd;
                if (ext_addr != ea) adr_bad++;
                if (wr && (ext_dout != ed || !ext_oe)) dat_bad++;
                pulses++;
            end
            prev = st;
            @(negedge clk);
            lat++;
        end
        check(lat < 400, "R4", "transaction watchdog", 64'(lat), 64'(np*(s+t+h)+1));
        check(sel_ok, "R2", "bank select", 64'(ext_cs_n), 64'(exp_cs));
        check(lat == np*(s+t+h)+1, "R4", "response latency", 64'(lat), 64'(np*(s+t+h)+1));
        check(strb == np*t, "R4", "strobe-low cycles", 64'(strb), 64'(np*t));
        check(pulses == np && wrong_strb == 0, "R5", "strobe pulses", 64'(pulses), 64'(np));
        check(adr_bad == 0, "R6", "part address order", 64'(adr_bad), 64'd0);
        check(cs_bad == 0, "R9", "select held through sequence", 64'(cs_bad), 64'd0);
        check(rdy_bad == 0 && !rsp_err, "R10", "busy and no error", 64'(rdy_bad), 64'd0);
        if (wr) check(dat_bad == 0, "R7", "write lanes", 64'(dat_bad), 64'd0);
        else    check(rsp_rdata == exp_rd, "R8", "packed read", 64'(rsp_rdata), 64'(exp_rd));
        @(negedge clk);
        check(req_ready && !rsp_valid, "R10", "ready again, pulse ended",
              64'({req_ready, rsp_valid}), 64'b10);
    endtask

    task automatic do_err(input logic [26:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid && rsp_err && ext_cs_n == 4'hF && ext_rd_n && ext_wr_n, "R3",
              "miss response", 64'({rsp_valid, rsp_err, ext_cs_n, ext_rd_n, ext_wr_n}), 64'b11111111);
        @(negedge clk);
        check(req_ready && !rsp_valid && ext_cs_n == 4'hF, "R3", "miss quiet after",
              64'({req_ready, rsp_valid, ext_cs_n}), 64'b101111);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0;
        cfg_setup = '0; cfg_strobe = '0; cfg_hold = '0; cfg_width = '0;
        repeat (3) @(negedge clk);
        check(req_ready && ext_cs_n == 4'hF && ext_rd_n && ext_wr_n && !rsp_valid, "R1",
              "reset state", 64'({req_ready, ext_cs_n, ext_rd_n, ext_wr_n, rsp_valid}), 64'b11111110);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && ext_cs_n == 4'hF && !rsp_valid, "R1", "after reset",
              64'({req_ready, ext_cs_n, rsp_valid}), 64'b111110);

        for (int ti = 0; ti < 5; ti++)
            for (int w = 0; w < 4; w++)
                for (int b = 0; b < 4; b++)
                    for (int wr = 0; wr < 2; wr++) begin
                        logic [23:0] off = 24'((ti*40961 + w*1297 + b*71 + wr*5 + 3) & 24'h3FFFFF);
                        logic [31:0] wd  = 32'h1234_5678 ^ (32'(ti) << 28) ^ (32'(w) << 20) ^ (32'(b) << 8) ^ 32'(wr);
                        set_bank(b, w, tS[ti], tT[ti], tH[ti]);
                        do_txn(b, bit'(wr), off, wd);
                    end

        // window edges (R2)
        set_bank(0, 0, 1, 2, 1);
        do_txn(0, 1'b0, 24'hDFFFFF, 32'h0);
        set_bank(3, 1, 2, 1, 1);
        do_txn(3, 1'b1, 24'hFFFFFF, 32'hCAFE_F00D);
        set_bank(1, 2, 0, 0, 0);
        do_txn(1, 1'b0, 24'h000000, 32'h0);

        // misses (R3)
        do_err(27'h0E00000);
        do_err(27'h0FFFFFF);
        do_err(27'h4000000);
        do_err(27'h7FFFFFF);
        do_err(27'h5000001);

        // normal traffic still works after a miss
        do_txn(0, 1'b1, 24'h000010, 32'hA5A5_5A5A);

        summary();
    end

endmodule